// File: doc/BRIEF.md
# PLL Clock Control Register

This block is the byte-wide control register that software uses to steer a small microcontroller's clock generator. The register holds a PLL enable, a two-bit multiplication ratio, the system clock source choice (oscillator or PLL output) and two free peripheral clock select bits. It also enforces the ordering rules that keep the clock switch safe. The PLL itself and the glitch-free clock multiplexer sit outside this block and only consume its control outputs.

Three interlocks guard the switch. First, the ratio may be changed once after reset, and only by a write that also drops the system clock back to the oscillator. Second, turning the PLL off forces the oscillator selection and holds it there. Third, a settle timer, counted in reference ticks, must run out after reset and after every accepted ratio change before the PLL output may be selected. A stop or test mode input forces the PLL off without altering the stored bits.

Top module: `clkctl_reg`

## Requirements
- R1: After reset the read value is 0x1B. This is PLL enabled, ratio code 2'b10 (x3), oscillator selected and peripheral bits 00. The ready output is 0 and the settle counter is loaded with SETTLE_TICKS.
- R2: Read data is {periph[1:0], sysclk_sel, 1, ratio[1:0], enable, 1} from bit 7 down to bit 0. Bits 4 and 0 always read 1, whatever is written to them.
- R3: pll_on equals the enable bit (bit 1) while halt_mode is 0, and is 0 while halt_mode is 1. halt_mode leaves the stored bits unchanged.
- R4: The ratio codes are 01 for x2, 10 for x3 and 11 for x4. A write carrying code 00 leaves the ratio unchanged.
- R5: Only one ratio change is accepted after reset. Later writes to bits 3:2 are ignored.
- R6: A ratio change is accepted only when the same write has bit 5 at 0. A write with bit 5 at 1 leaves the ratio unchanged.
- R7: A write with bit 1 at 0 clears the system clock select. While the stored enable is 0, a write of 1 to bit 5 leaves it at 0.
- R8: The settle counter decrements on each ref_tick until it reaches zero. It reloads to SETTLE_TICKS on an accepted ratio change. A write of 1 to bit 5 sets the system clock select only when the counter is zero.
- R9: Bits 7:6 store the written value on every write, with no interlock.
- R10: pll_ready is 1 exactly when the settle counter is zero, the enable is 1 and halt_mode is 0.
- R11: No register bit changes unless reg_sel and wr_en are both 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse of the reference time base |
| halt_mode | input | 1 | Stop or test mode; forces the PLL off |
| reg_sel | input | 1 | Address match for this register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| pll_on | output | 1 | PLL run control |
| pll_ratio | output | 2 | Multiplication ratio code |
| sysclk_pll | output | 1 | System clock source: 1 selects the PLL output |
| periph_sel | output | 2 | Peripheral clock select bits |
| pll_ready | output | 1 | Settled, enabled and not halted |

## Verification
The assertions assume that reg_sel, wr_en, ref_tick and halt_mode are always 0 or 1, never unknown, and that ref_tick is sampled only on clock edges. They also assume that reset is applied before the first write. The bench drives every input from a single initial block, away from the active clock edge, and holds all of them at defined values from time zero. It mixes directed writes, which reach each interlock in turn, with random write data, random select and strobe patterns, random ticks and occasional halt pulses. This produces ignored, accepted and forced-clear writes in many orders.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    // Stored fields of the control register
    typedef struct packed {
        logic       en;      // PLL enable
        logic [1:0] ratio;   // multiplication code
        logic       used;    // ratio change already consumed
        logic       sel;     // system clock from PLL
        logic [1:0] per;     // peripheral clock selects
    } ctl_t;

    localparam int POS_EN    = 1;
    localparam int POS_RLO   = 2;
    localparam int POS_SEL   = 5;
    localparam int POS_PLO   = 6;
    localparam logic [1:0] RATIO_BAD = 2'b00;
    localparam logic [1:0] RATIO_RST = 2'b10;

    function automatic logic [7:0] pack_rd(input ctl_t c);
        return {c.per, c.sel, 1'b1, c.ratio, c.en, 1'b1};
    endfunction

endpackage

// File: rtl/clkctl_settle.sv
module clkctl_settle #(
    parameter int TICKS = 2000,
    localparam int W = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reload,
    output logic zero
);
    localparam logic [W-1:0] LOAD = W'(TICKS);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload) begin
            cnt_d = LOAD;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    assert_tick_decrements_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_reload_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == LOAD));

endmodule

// File: rtl/clkctl_wrgate.sv
module clkctl_wrgate
    import clkctl_pkg::*;
(
    input  ctl_t       cur,
    input  logic       wr,
    input  logic [7:0] wd,
    input  logic       settled,
    output ctl_t       nxt,
    output logic       ratio_take
);
    logic [1:0] wr_ratio;
    logic       wr_en_bit;
    logic       wr_sel_bit;

    always_comb begin
        wr_ratio   = wd[POS_RLO +: 2];
        wr_en_bit  = wd[POS_EN];
        wr_sel_bit = wd[POS_SEL];
        nxt        = cur;
        ratio_take = 1'b0;
        if (wr) begin
            // ratio: once per reset, only with clock select cleared, never code 00
            ratio_take = !cur.used && !wr_sel_bit &&
                         (wr_ratio != RATIO_BAD) && (wr_ratio != cur.ratio);
            if (ratio_take) begin
                nxt.ratio = wr_ratio;
                nxt.used  = 1'b1;
            end
            nxt.en  = wr_en_bit;
            // select needs enable held before and after, plus a settled timer
            nxt.sel = cur.en && wr_en_bit && wr_sel_bit && settled;
            nxt.per = wd[POS_PLO +: 2];
        end
    end

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
    import clkctl_pkg::*;
#(
    parameter int SETTLE_TICKS = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       halt_mode,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       pll_on,
    output logic [1:0] pll_ratio,
    output logic       sysclk_pll,
    output logic [1:0] periph_sel,
    output logic       pll_ready
);
    localparam ctl_t CTL_RST = '{en: 1'b1, ratio: RATIO_RST, used: 1'b0,
                                 sel: 1'b0, per: 2'b00};

    ctl_t ctl_d, ctl_q;
    logic wr_hit;
    logic settled;
    logic ratio_take;

    assign wr_hit = reg_sel && wr_en;

    clkctl_wrgate u_gate (
        .cur        (ctl_q),
        .wr         (wr_hit),
        .wd         (wr_data),
        .settled    (settled),
        .nxt        (ctl_d),
        .ratio_take (ratio_take)
    );

    clkctl_settle #(.TICKS(SETTLE_TICKS)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ref_tick),
        .reload (ratio_take),
        .zero   (settled)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rd_data    = pack_rd(ctl_q);
    assign pll_on     = ctl_q.en && !halt_mode;
    assign pll_ratio  = ctl_q.ratio;
    assign sysclk_pll = ctl_q.sel;
    assign periph_sel = ctl_q.per;
    assign pll_ready  = settled && ctl_q.en && !halt_mode;

    assert_sel_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.sel |-> ctl_q.en);

    assert_ratio_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ratio != RATIO_BAD);

    assert_ratio_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.used |=> $stable(ctl_q.ratio));

    assert_sel_after_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.sel) |-> $past(settled));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctl_q));

    assert_ready_implies_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ready |-> pll_on);

endmodule

// File: tb/clkctl_reg_tb.sv
module clkctl_reg_tb_top;
    localparam int TICKS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       halt_mode = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pll_on, sysclk_pll, pll_ready;
    logic [1:0] pll_ratio, periph_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    bit       m_en, m_used, m_sel;
    bit [1:0] m_ratio, m_per;
    int       m_cnt;

    always #4 clk = ~clk;

    clkctl_reg #(.SETTLE_TICKS(TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .halt_mode(halt_mode),
        .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pll_on(pll_on), .pll_ratio(pll_ratio), .sysclk_pll(sysclk_pll),
        .periph_sel(periph_sel), .pll_ready(pll_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_rd();
        return {m_per, m_sel, 1'b1, m_ratio, m_en, 1'b1};
    endfunction

    task automatic check_all(input string tag);
        check({tag, " R2 rd_data"}, rd_data, exp_rd());
        check({tag, " R3 pll_on"}, pll_on, m_en && !halt_mode);
        check({tag, " R4 ratio"}, pll_ratio, m_ratio);
        check({tag, " R7 sysclk"}, sysclk_pll, m_sel);
        check({tag, " R9 periph"}, periph_sel, m_per);
        check({tag, " R10 ready"}, pll_ready, (m_cnt == 0) && m_en && !halt_mode);
    endtask

    task automatic model(input bit wr, input bit [7:0] d, input bit t);
        bit tz, take;
        tz   = (m_cnt == 0);
        take = 0;
        if (wr) begin
            take = !m_used && !d[5] && d[3:2] != 2'b00 && d[3:2] != m_ratio;
            if (take) begin m_ratio = d[3:2]; m_used = 1; end
            m_sel = m_en && d[1] && d[5] && tz;
            m_en  = d[1];
            m_per = d[7:6];
        end
        if (take)              m_cnt = TICKS;
        else if (t && m_cnt != 0) m_cnt = m_cnt - 1;
    endtask

    task automatic step(input string tag, input bit s, input bit w,
                        input bit [7:0] d, input bit t, input bit h);
        reg_sel = s; wr_en = w; wr_data = d; ref_tick = t; halt_mode = h;
        @(posedge clk); #2;
        model(s && w, d, t);
        check_all(tag);
    endtask

    task automatic wr(input string tag, input bit [7:0] d);
        step(tag, 1, 1, d, 0, 0);
    endtask

    task automatic settle(input string tag);
        for (int i = 0; i < TICKS + 2; i++) step(tag, 0, 0, 8'h00, 1, 0);
    endtask

    initial begin
        void'($urandom(32'd7711));
        m_en = 1; m_used = 0; m_sel = 0; m_ratio = 2'b10; m_per = 0; m_cnt = TICKS;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset rd_data", rd_data, 8'h1B);
        check("R1 reset ready", pll_ready, 0);
        check_all("R1");
        // R8 select refused before settle
        wr("R8 early select", 8'h2A);
        check("R8 early select stays 0", sysclk_pll, 0);
        // R4 code 00 ignored
        wr("R4 code 00", 8'h02);
        check("R4 code 00 keeps ratio", pll_ratio, 2'b10);
        // R6 ratio with bit5 set ignored
        wr("R6 ratio with sel", 8'h2E);
        check("R6 ratio unchanged", pll_ratio, 2'b10);
        // R11 strobe without select
        step("R11 no reg_sel", 0, 1, 8'hC0, 0, 0);
        step("R11 no wr_en", 1, 0, 8'hC0, 0, 0);
        check("R11 periph unchanged", periph_sel, 2'b00);
        settle("R8 settle");
        check("R10 ready after settle", pll_ready, 1);
        // accepted ratio change reloads timer
        wr("R5 first change", 8'h0E);
        check("R5 ratio now x4", pll_ratio, 2'b11);
        check("R8 reload drops ready", pll_ready, 0);
        wr("R5 second change", 8'h06);
        check("R5 second change ignored", pll_ratio, 2'b11);
        settle("R8 settle 2");
        wr("R8 select after settle", 8'h2E);
        check("R8 select set", sysclk_pll, 1);
        // R7 disable clears and locks
        wr("R7 disable", 8'h00);
        check("R7 select cleared", sysclk_pll, 0);
        wr("R7 locked select", 8'h20);
        wr("R7 enable with select", 8'h22);
        check("R7 select discarded while disabled", sysclk_pll, 0);
        wr("R7 select again", 8'h22);
        check("R7 select accepted", sysclk_pll, 1);
        // R3 halt
        step("R3 halt", 0, 0, 8'h00, 0, 1);
        check("R3 halt forces off", pll_on, 0);
        check("R3 halt keeps enable bit", rd_data[1], 1);
        // R9 periph
        wr("R9 periph", 8'hE3);
        check("R9 periph set", periph_sel, 2'b11);
        check("R2 fixed bits", {rd_data[4], rd_data[0]}, 2'b11);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] d;
            d = 8'($urandom);
            if ($urandom % 3 == 0) d[1] = 1'b1;
            step("rand", ($urandom % 4) != 0, $urandom % 2, d,
                 ($urandom % 2) == 0, ($urandom % 16) == 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule